// File: doc/BRIEF.md
# MDIO Management Master with Host Command Register

This block lets a host reach the registers of an external PHY over a two-wire management bus: a clock output (MDC) and one shared data line (MDIO), which leaves the block as an output value and an output enable and comes back as an input. The host writes one 32-bit command word. That word selects the operation and holds the PHY address, the register address and, for a write, the 16-bit data. The block then shifts out a management frame. For a read, it captures the PHY's 16 data bits back into the data field of the same word.

Completion shows up in three ways: a done flag in the word, a one-cycle interrupt pulse, and the release of any stalled host read. There are two read styles. A blocking read stalls the host's register reads until the data has arrived. A non-blocking read returns at once, and the host either polls the done flag or waits for the interrupt. A per-command flag drops the 32-bit preamble, which shortens the frame by half. MDC runs at the system clock divided by `2*DIV_HALF`. MDC toggles only while a frame is running.

Top module: `mdio_host_master`

## Requirements
- R1: After reset, every bit of the host word reads 0, MDC is low, the MDIO output enable is low, the interrupt is low and the read-ready output is high.
- R2: Host word layout. Bit 31 is done and is read-only. Bit 30 is the write command. Bit 29 is the blocking read. Bit 28 is the non-blocking read. Bit 27 suppresses the preamble. Bit 26 always reads 0. Bits 25:21 hold the PHY address, bits 20:16 the register address and bits 15:0 the data.
- R3: An accepted host write clears done on the next cycle. Done stays 0 until the last bit of the launched frame has ended. It then rises in the same cycle as the interrupt.
- R4: The completion interrupt is high for exactly one cycle per finished frame.
- R5: A write frame has these fields, in order: 32 ones, 01, 01, the 5-bit PHY address, the 5-bit register address, 10, and the 16 data bits, MSB first. Each field is sent MSB first. Every bit lasts one MDC period of `2*DIV_HALF` clocks. MDC is low at the start of each bit, and MDIO changes only while MDC is low. The output enable stays high for the whole write frame.
- R6: A read frame uses opcode 10. The output enable drops at the first turnaround bit, which is frame bit 46 counted from 0 at the first preamble bit, and stays low to the end. The 16 bits sampled on the rising MDC edges of the data bits go into bits 15:0, MSB first, when done rises.
- R7: When bit 27 is set, the frame starts directly with the start code, so it lasts 32 MDC periods instead of 64.
- R8: While a blocking read is in progress, a host read request sees read-ready low. Read-ready returns high in the cycle in which done is 1 and the read data is in the word. A non-blocking read never lowers read-ready.
- R9: A host write with more than one of bits 30, 29 and 28 set is ignored, so the word, including done, is left unchanged and no frame starts.
- R10: A host write that arrives while a frame is running is ignored.
- R11: A host write with none of the three command bits set loads its fields and clears done. It starts no frame, so MDC stays low.
- R12: When done rises, bits 30, 29 and 28 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe for the command word |
| reg_wdata | input | 32 | Host write data |
| reg_rd | input | 1 | Host read request |
| reg_rdata | output | 32 | Current command word |
| reg_rd_ready | output | 1 | Low while a host read must be held off |
| done_irq | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench targets the edges of the frame:
- The turnaround bit where the enable must drop on reads. A design that releases one bit late would fight the PHY.
- The last data bit. A capture that is off by one would shift the read word.
- The final MDC fall, where done, the interrupt and the return of read-ready must coincide. A design that raises done before the data lands would let a blocked host read stale data.

Illegal command mixes, writes during a running frame and command-less writes are each followed by a read-back of the word. This shows that nothing was launched or overwritten. The stall length of a blocking read with the preamble suppressed is measured to confirm the shortened frame.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;

   localparam int FRAME_BITS = 64;
   localparam int PRE_BITS   = 32;
   localparam int TA_POS     = 46;
   localparam int DATA_POS   = 48;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   typedef struct packed {
      logic        done;
      logic        cmd_wr;
      logic        cmd_rd_blk;
      logic        cmd_rd_nblk;
      logic        no_pre;
      logic        rsv;
      logic [4:0]  phy;
      logic [4:0]  regad;
      logic [15:0] data;
   } host_word_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);

   localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   logic term;

   generate
      if (DIV_HALF == 1) begin : g_direct
         assign term = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         assign term = (cnt == CNT_W'(DIV_HALF - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !en) begin
               cnt <= '0;
            end else if (term) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

   assign rise_tick = en && term && !mdc;
   assign fall_tick = en && term && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         mdc <= 1'b0;
      end else if (term) begin
         mdc <= ~mdc;
      end
   end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_host_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        start_rd,
   input  logic        start_no_pre,
   input  logic [4:0]  start_phy,
   input  logic [4:0]  start_reg,
   input  logic [15:0] start_data,
   input  logic        rise_tick,
   input  logic        fall_tick,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        fin,
   output logic [15:0] rd_word
);

   logic [FRAME_BITS-1:0] sr;
   logic [IDX_W-1:0]      idx;
   logic                  is_rd;
   logic [15:0]           cap;
   logic [FRAME_BITS-1:0] frame;
   logic [IDX_W-1:0]      first_idx;

   always_comb begin
      frame = {{PRE_BITS{1'b1}}, 2'b01,
               (start_rd ? 2'b10 : 2'b01),
               start_phy, start_reg,
               (start_rd ? 2'b00 : 2'b10),
               (start_rd ? 16'h0000 : start_data)};
      first_idx = start_no_pre ? IDX_W'(PRE_BITS) : '0;
   end

   assign fin     = busy && fall_tick && (idx == IDX_W'(FRAME_BITS - 1));
   assign mdio_o  = sr[FRAME_BITS-1];
   assign mdio_oe = busy && !(is_rd && (idx >= IDX_W'(TA_POS)));
   assign rd_word = cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         is_rd <= 1'b0;
         sr    <= '0;
         idx   <= '0;
         cap   <= '0;
      end else if (start && !busy) begin
         busy  <= 1'b1;
         is_rd <= start_rd;
         sr    <= frame << first_idx;
         idx   <= first_idx;
         cap   <= '0;
      end else if (busy) begin
         if (rise_tick && is_rd && (idx >= IDX_W'(DATA_POS))) begin
            cap <= {cap[14:0], mdio_i};
         end
         if (fall_tick) begin
            sr  <= sr << 1;
            idx <= idx + 1'b1;
            if (fin) begin
               busy <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/mdio_host_reg.sv
module mdio_host_reg
   import mdio_host_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   input  logic        rd_en,
   input  logic        busy,
   input  logic        fin,
   input  logic [15:0] rd_word,
   output logic [31:0] rdata,
   output logic        rd_ready,
   output logic        irq,
   output logic        start,
   output logic        start_rd,
   output logic        start_no_pre,
   output logic [4:0]  start_phy,
   output logic [4:0]  start_reg,
   output logic [15:0] start_data
);

   host_word_t word;
   host_word_t wnew;
   logic [1:0] ncmd;
   logic       accept;

   always_comb begin
      wnew   = host_word_t'(wdata);
      ncmd   = {1'b0, wnew.cmd_wr} + {1'b0, wnew.cmd_rd_blk} + {1'b0, wnew.cmd_rd_nblk};
      accept = wr_en && !busy && (ncmd <= 2'd1);
   end

   assign start        = accept && (ncmd == 2'd1);
   assign start_rd     = !wnew.cmd_wr;
   assign start_no_pre = wnew.no_pre;
   assign start_phy    = wnew.phy;
   assign start_reg    = wnew.regad;
   assign start_data   = wnew.data;

   assign rdata    = word;
   assign rd_ready = !(rd_en && word.cmd_rd_blk && !word.done);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
         irq  <= 1'b0;
      end else begin
         irq <= fin;
         if (fin) begin
            word.done        <= 1'b1;
            word.cmd_wr      <= 1'b0;
            word.cmd_rd_blk  <= 1'b0;
            word.cmd_rd_nblk <= 1'b0;
            if (!word.cmd_wr) begin
               word.data <= rd_word;
            end
         end else if (accept) begin
            word      <= wnew;
            word.done <= 1'b0;
            word.rsv  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mdio_host_master.sv
module mdio_host_master #(
   parameter int DIV_HALF = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   input  logic        reg_rd,
   output logic [31:0] reg_rdata,
   output logic        reg_rd_ready,
   output logic        done_irq,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   generate
      if (DIV_HALF < 1) begin : g_bad_div
         $error("DIV_HALF must be at least 1");
      end
   endgenerate

   logic        busy;
   logic        fin;
   logic        rise_tick;
   logic        fall_tick;
   logic [15:0] rd_word;
   logic        start;
   logic        start_rd;
   logic        start_no_pre;
   logic [4:0]  start_phy;
   logic [4:0]  start_reg;
   logic [15:0] start_data;

   mdio_host_reg u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (reg_wr),
      .wdata        (reg_wdata),
      .rd_en        (reg_rd),
      .busy         (busy),
      .fin          (fin),
      .rd_word      (rd_word),
      .rdata        (reg_rdata),
      .rd_ready     (reg_rd_ready),
      .irq          (done_irq),
      .start        (start),
      .start_rd     (start_rd),
      .start_no_pre (start_no_pre),
      .start_phy    (start_phy),
      .start_reg    (start_reg),
      .start_data   (start_data)
   );

   mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_mdc (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (busy),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .start_rd     (start_rd),
      .start_no_pre (start_no_pre),
      .start_phy    (start_phy),
      .start_reg    (start_reg),
      .start_data   (start_data),
      .rise_tick    (rise_tick),
      .fall_tick    (fall_tick),
      .mdio_i       (mdio_i),
      .busy         (busy),
      .mdio_o       (mdio_o),
      .mdio_oe      (mdio_oe),
      .fin          (fin),
      .rd_word      (rd_word)
   );

endmodule

// File: rtl/mdio_host_chk.sv
module mdio_host_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_rd,
   input logic [31:0] reg_rdata,
   input logic        reg_rd_ready,
   input logic        done_irq,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);

   // R3
   done_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[31]) |-> done_irq);

   // R3
   irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> reg_rdata[31]);

   // R4
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);

   // R5
   mdc_quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[31] |-> !mdc);

   // R5
   mdio_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc);

   // R8
   stall_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_ready |-> (reg_rd && !reg_rdata[31] && reg_rdata[29]));

endmodule

bind mdio_host_master mdio_host_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_rd       (reg_rd),
   .reg_rdata    (reg_rdata),
   .reg_rd_ready (reg_rd_ready),
   .done_irq     (done_irq),
   .mdc          (mdc),
   .mdio_o       (mdio_o),
   .mdio_oe      (mdio_oe)
);

// File: tb/tb_mdio_host_master.sv
`timescale 1ns/1ps
module tb_mdio_host_master;

   localparam int D = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_rdata;
   logic        reg_rd_ready;
   logic        done_irq;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   mdio_host_master #(.DIV_HALF(D)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rd_ready(reg_rd_ready),
      .done_irq(done_irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   always #10 clk = ~clk;

   int errs = 0;
   int checks = 0;
   int irq_cnt = 0;
   bit finished = 0;

   // reference model state
   logic [31:0] m_word = '0;
   bit          m_busy = 0;
   bit          m_isrd = 0;
   bit          m_irq = 0;
   int          m_k = 0;
   int          m_idx0 = 0;
   int          m_nbits = 0;
   logic [63:0] m_frame = '0;
   logic [15:0] phy_val = 16'h0000;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      m_irq = 0;
      if (!rst_n) begin
         m_word = '0;
         m_busy = 0;
      end else if (m_busy) begin
         m_k++;
         if (m_k == 2 * D * m_nbits) begin
            m_busy = 0;
            m_irq = 1;
            m_word[31] = 1'b1;
            m_word[30:28] = 3'b000;
            if (m_isrd) m_word[15:0] = phy_val;
         end
      end else if (reg_wr) begin
         int n;
         n = int'(reg_wdata[30]) + int'(reg_wdata[29]) + int'(reg_wdata[28]);
         if (n <= 1) begin
            m_word = {1'b0, reg_wdata[30:27], 1'b0, reg_wdata[25:0]};
            if (n == 1) begin
               m_busy = 1;
               m_k = 0;
               m_isrd = !reg_wdata[30];
               m_idx0 = reg_wdata[27] ? 32 : 0;
               m_nbits = 64 - m_idx0;
               m_frame = {32'hFFFF_FFFF, 2'b01, (m_isrd ? 2'b10 : 2'b01),
                          reg_wdata[25:21], reg_wdata[20:16],
                          (m_isrd ? 2'b00 : 2'b10),
                          (m_isrd ? 16'h0000 : reg_wdata[15:0])};
            end
         end
      end
   end

   // PHY side: drive the read bits during the data field
   always @(negedge clk) begin
      if (m_busy && m_isrd) begin
         int pos;
         pos = m_idx0 + m_k / (2 * D);
         mdio_i <= (pos >= 48) ? phy_val[15 - (pos - 48)] : 1'b1;
      end else begin
         mdio_i <= 1'b1;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      #2;
      if (rst_n && !finished) begin
         logic emdc, eoe, eo;
         int pos;
         emdc = 1'b0; eoe = 1'b0; eo = 1'b0; pos = 0;
         if (m_busy) begin
            pos  = m_idx0 + m_k / (2 * D);
            emdc = ((m_k / D) % 2) == 1;
            eoe  = !(m_isrd && pos >= 46);
            eo   = m_frame[63 - pos];
         end
         check("R3 done", {31'b0, reg_rdata[31]}, {31'b0, m_word[31]});
         check("R2 word", {1'b0, reg_rdata[30:0]}, {1'b0, m_word[30:0]});
         check("R4 irq", {31'b0, done_irq}, {31'b0, m_irq});
         check("R5 mdc", {31'b0, mdc}, {31'b0, emdc});
         check("R6 oe", {31'b0, mdio_oe}, {31'b0, eoe});
         if (eoe) begin
            if (m_idx0 == 32) check("R7 mdio", {31'b0, mdio_o}, {31'b0, eo});
            else              check("R5 mdio", {31'b0, mdio_o}, {31'b0, eo});
         end
         check("R8 ready", {31'b0, reg_rd_ready},
               {31'b0, !(reg_rd && m_word[29] && m_busy)});
         if (done_irq) irq_cnt++;
      end
   end

   task automatic host_write(logic [31:0] w);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = w;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      #4;
   endtask

   function automatic logic [31:0] mk(logic [3:0] cmd, logic [4:0] pa,
                                      logic [4:0] ra, logic [15:0] d);
      return {1'b0, cmd, 1'b0, pa, ra, d};
   endfunction

   task automatic finish_run();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      errs++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] prev;
      int stall, irq0;
      repeat (3) @(negedge clk);
      #4;
      // R1: reset state
      check("R1 rdata", reg_rdata, 32'h0);
      check("R1 outputs", {28'b0, mdc, mdio_oe, done_irq, reg_rd_ready}, 32'h1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5: write frame with preamble
      irq0 = irq_cnt;
      host_write(mk(4'b1000, 5'h13, 5'h04, 16'hA5C3));
      wait_idle();
      check("R4 one pulse", irq_cnt - irq0, 1);
      check("R12 cmd clear", {29'b0, reg_rdata[30:28]}, 32'h0);
      check("R3 done set", {31'b0, reg_rdata[31]}, 32'h1);

      // R6: non-blocking read, polled with reg_rd held
      phy_val = 16'h3C96;
      host_write(mk(4'b0010, 5'h01, 5'h1F, 16'hFFFF));
      reg_rd = 1'b1;
      wait_idle();
      reg_rd = 1'b0;
      check("R6 nblk data", {16'b0, reg_rdata[15:0]}, 32'h3C96);

      // R7, R8: blocking read without preamble, measure the stall
      phy_val = 16'hF00D;
      host_write(mk(4'b0101, 5'h0A, 5'h11, 16'h0000));
      reg_rd = 1'b1;
      stall = 0;
      forever begin
         @(negedge clk);
         #3;
         if (reg_rd_ready) break;
         stall++;
      end
      check("R7 short frame stall", stall, 2 * D * 32 - 1);
      check("R8 data on release", reg_rdata, {1'b1, 3'b000, 1'b1, 1'b0, 5'h0A, 5'h11, 16'hF00D});
      @(negedge clk);
      reg_rd = 1'b0;
      wait_idle();

      // R9: two command bits at once
      prev = reg_rdata;
      host_write(mk(4'b1100, 5'h07, 5'h07, 16'h1234));
      repeat (20) @(negedge clk);
      #4;
      check("R9 ignored", reg_rdata, prev);
      check("R9 no mdc", {31'b0, mdc}, 32'h0);

      // R10: write during a running frame
      host_write(mk(4'b1000, 5'h02, 5'h03, 16'h5555));
      repeat (30) @(negedge clk);
      host_write(mk(4'b1000, 5'h1C, 5'h1D, 16'hAAAA));
      wait_idle();
      check("R10 first kept", {1'b0, reg_rdata[30:0]}, {1'b0, 3'b000, 1'b0, 1'b0, 5'h02, 5'h03, 16'h5555});

      // R11: no command bit, reserved bit set in the write
      host_write({1'b1, 3'b000, 1'b1, 1'b1, 5'h15, 5'h0B, 16'hBEEF});
      repeat (20) @(negedge clk);
      #4;
      check("R11 fields", reg_rdata, {1'b0, 3'b000, 1'b1, 1'b0, 5'h15, 5'h0B, 16'hBEEF});
      check("R11 no mdc", {31'b0, mdc}, 32'h0);

      // R6: read with preamble, another value
      phy_val = 16'h8001;
      host_write(mk(4'b0010, 5'h00, 5'h00, 16'h0000));
      wait_idle();
      check("R6 edge bits", {16'b0, reg_rdata[15:0]}, 32'h8001);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule